// File: doc/BRIEF.md
# Bit-Slice ALU with Carry Lookahead

This block is a small integer ALU assembled from identical one-bit slices and a separate carry-lookahead unit. Each slice handles one operand bit. It can invert its b bit, and it forms the AND, the OR and the full-adder sum of the two bits. It also passes through a less-than input, and it exports a generate and a propagate term. The lookahead unit takes all generate and propagate terms plus the external carry-in. It returns the carry into every slice as a flat sum-of-products, so no carry ripples from slice to slice.

The operation is chosen by a two-bit select and a b-invert flag. Subtraction is addition with b inverted and a carry-in of 1. For set-on-less-than, the select picks the less input. Slice 0 receives the sign bit of the full-width sum, and the upper slices receive 0. With b inverted and carry-in 1, the result is 1 exactly when the difference a − b is negative. The result and the carry-out are captured in output registers that clear on a synchronous active-high reset.

Top module: `alu_bitslice_top`

## Requirements
- R1: With op_sel=00 the result is a AND b', where b' is b_in XOR'ed with b_flip on every bit.
- R2: With op_sel=01 the result is a OR b'.
- R3: With op_sel=10 the result is the low WIDTH bits of a + b' + c_in.
- R4: With op_sel=10, b_flip=1 and c_in=1 the result is a − b modulo 2^WIDTH.
- R5: With op_sel=11 result bit 0 equals bit WIDTH-1 of a + b' + c_in, and all higher result bits are 0. With b_flip=1 and c_in=1 this is the sign of a − b.
- R6: cout_q is the carry out of bit WIDTH-1 of a + b' + c_in, whatever op_sel is.
- R7: The carry into every slice equals the ripple carry of the same sum, for all operand and carry-in values.
- R8: Outputs change only on a rising clock edge, one cycle after their inputs. When rst is high at an edge, res_q and cout_q become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | WIDTH | Operand a |
| b_in | input | WIDTH | Operand b |
| b_flip | input | 1 | Invert b before every operation |
| op_sel | input | 2 | 00 AND, 01 OR, 10 sum, 11 less-than pass |
| c_in | input | 1 | Carry into slice 0 |
| res_q | output | WIDTH | Registered result |
| cout_q | output | 1 | Registered carry-out |

## Verification
The assertions assume that the inputs are stable and known at every rising edge, and that rst is high at the first edges, so that each $past value is a driven value. The bench changes inputs only on falling edges, so every rising edge sees settled operands. It holds rst high for two edges before it applies any operation. Less-than cases are driven with b_flip=1 and c_in=1, because the sign interpretation only holds under that setting.

// File: rtl/alu_bitslice_pkg.sv
package alu_bitslice_pkg;
  typedef enum logic [1:0] {
    OP_AND  = 2'b00,
    OP_OR   = 2'b01,
    OP_SUM  = 2'b10,
    OP_LESS = 2'b11
  } alu_op_e;
endpackage

// File: rtl/alu_slice.sv
module alu_slice
  import alu_bitslice_pkg::*;
(
  input  logic    a_bit,
  input  logic    b_bit,
  input  logic    flip,
  input  logic    cin,
  input  logic    less,
  input  alu_op_e op,
  output logic    res,
  output logic    gen,
  output logic    prop,
  output logic    sum
);
  logic bx;

  assign bx   = b_bit ^ flip;
  assign gen  = a_bit & bx;
  assign prop = a_bit | bx;
  assign sum  = a_bit ^ bx ^ cin;

  always_comb begin
    unique case (op)
      OP_AND:  res = gen;
      OP_OR:   res = prop;
      OP_SUM:  res = sum;
      default: res = less;
    endcase
  end
endmodule

// File: rtl/cla_unit.sv
module cla_unit #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] g,
  input  logic [WIDTH-1:0] p,
  input  logic             c0,
  output logic [WIDTH:0]   c
);
  // gc[0] is the external carry, gc[j] for j>0 is generate of bit j-1
  logic [WIDTH:0] gc;
  assign gc = {g, c0};

  always_comb begin
    logic acc;
    logic term;
    c[0] = c0;
    for (int i = 0; i < WIDTH; i++) begin
      acc = 1'b0;
      for (int j = 0; j <= i; j++) begin
        term = gc[j];
        for (int k = j; k <= i; k++) term = term & p[k];
        acc = acc | term;
      end
      c[i+1] = acc | g[i];
    end
  end
endmodule

// File: rtl/alu_bitslice_top.sv
module alu_bitslice_top
  import alu_bitslice_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic             b_flip,
  input  logic [1:0]       op_sel,
  input  logic             c_in,
  output logic [WIDTH-1:0] res_q,
  output logic             cout_q
);
  localparam int MSB = WIDTH - 1;

  alu_op_e          op;
  logic [WIDTH-1:0] gen, prop, sum, res, less;
  logic [WIDTH:0]   carry;

  assign op = alu_op_e'(op_sel);

  cla_unit #(.WIDTH(WIDTH)) u_cla (
    .g  (gen),
    .p  (prop),
    .c0 (c_in),
    .c  (carry)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    if (i == 0) begin : g_lsb
      assign less[i] = sum[MSB];
    end else begin : g_upper
      assign less[i] = 1'b0;
    end

    alu_slice u_slice (
      .a_bit (a_in[i]),
      .b_bit (b_in[i]),
      .flip  (b_flip),
      .cin   (carry[i]),
      .less  (less[i]),
      .op    (op),
      .res   (res[i]),
      .gen   (gen[i]),
      .prop  (prop[i]),
      .sum   (sum[i])
    );

    // R7
    carry_chain_chk: assert property (@(posedge clk) disable iff (rst)
      carry[i+1] == (gen[i] | (prop[i] & carry[i])));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q  <= '0;
      cout_q <= 1'b0;
    end else begin
      res_q  <= res;
      cout_q <= carry[WIDTH];
    end
  end

  // Arithmetic reference for the checks below
  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   arith_ref;
  assign b_eff     = b_in ^ {WIDTH{b_flip}};
  assign arith_ref = {1'b0, a_in} + {1'b0, b_eff} + {{WIDTH{1'b0}}, c_in};

  // R3
  sum_result_chk: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 2'b10) |=> (res_q == $past(arith_ref[MSB:0])));

  // R6
  carry_out_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (cout_q == $past(arith_ref[WIDTH])));

  // R5
  less_result_chk: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 2'b11) |=> (res_q == {{MSB{1'b0}}, $past(arith_ref[MSB])}));

  // R1
  and_result_chk: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 2'b00) |=> (res_q == $past(a_in & b_eff)));

  // R8
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (res_q == '0 && !cout_q));
endmodule

// File: tb/sim_alu_bitslice_top.sv
module sim_alu_bitslice_top;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic         b_flip = 1'b0, c_in = 1'b0;
  logic [1:0]   op_sel = 2'b00;
  logic [W-1:0] res_q;
  logic         cout_q;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  alu_bitslice_top #(.WIDTH(W)) u0 (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in), .b_flip(b_flip),
    .op_sel(op_sel), .c_in(c_in), .res_q(res_q), .cout_q(cout_q)
  );

  // {req, op, flip, cin, a, b, exp_res, exp_cout}
  localparam int NV = 16;
  localparam logic [20:0] TBL [NV] = '{
    {4'd1, 2'b00, 1'b0, 1'b0, 4'b1100, 4'b1010, 4'b1000, 1'b1}, // R1
    {4'd1, 2'b00, 1'b1, 1'b0, 4'b1100, 4'b1010, 4'b0100, 1'b1}, // R1 flipped b
    {4'd2, 2'b01, 1'b0, 1'b0, 4'b1100, 4'b1010, 4'b1110, 1'b1}, // R2
    {4'd2, 2'b01, 1'b1, 1'b0, 4'b0000, 4'b0110, 4'b1001, 1'b0}, // R2 flipped b
    {4'd3, 2'b10, 1'b0, 1'b0, 4'b0011, 4'b0101, 4'b1000, 1'b0}, // R3
    {4'd3, 2'b10, 1'b0, 1'b1, 4'b1111, 4'b0000, 4'b0000, 1'b1}, // R3 carry through all
    {4'd3, 2'b10, 1'b0, 1'b0, 4'b1001, 4'b0111, 4'b0000, 1'b1}, // R3
    {4'd3, 2'b10, 1'b0, 1'b1, 4'b0110, 4'b0110, 4'b1101, 1'b0}, // R3
    {4'd4, 2'b10, 1'b1, 1'b1, 4'b0111, 4'b0011, 4'b0100, 1'b1}, // R4 7-3
    {4'd4, 2'b10, 1'b1, 1'b1, 4'b0010, 4'b0101, 4'b1101, 1'b0}, // R4 2-5
    {4'd4, 2'b10, 1'b1, 1'b1, 4'b0101, 4'b0101, 4'b0000, 1'b1}, // R4 equal
    {4'd5, 2'b11, 1'b1, 1'b1, 4'b0010, 4'b0101, 4'b0001, 1'b0}, // R5 a<b
    {4'd5, 2'b11, 1'b1, 1'b1, 4'b0101, 4'b0101, 4'b0000, 1'b1}, // R5 a=b
    {4'd5, 2'b11, 1'b1, 1'b1, 4'b0110, 4'b0011, 4'b0000, 1'b1}, // R5 a>b
    {4'd5, 2'b11, 1'b1, 1'b1, 4'b1110, 4'b0001, 4'b0001, 1'b1}, // R5 -2<1
    {4'd6, 2'b01, 1'b0, 1'b1, 4'b1000, 4'b1000, 4'b1000, 1'b1}  // R6 carry on OR
  };

  task automatic check(input string req, input logic [W:0] act, input logic [W:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got {cout,res}=%b expected %b", req, act, exp);
    end
  endtask

  task automatic apply(input logic [1:0] op, input logic fl, input logic ci,
                       input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    op_sel = op; b_flip = fl; c_in = ci; a_in = a; b_in = b;
    @(posedge clk);
    #5;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R8 reset state
    repeat (2) @(posedge clk);
    #5;
    check("R8 reset", {cout_q, res_q}, '0);
    @(negedge clk);
    rst = 1'b0;

    for (int v = 0; v < NV; v++) begin
      logic [20:0] e;
      string tag;
      e = TBL[v];
      apply(e[16:15], e[14], e[13], e[12:9], e[8:5]);
      tag = $sformatf("R%0d vector %0d", e[20:17], v);
      check(tag, {cout_q, res_q}, {e[0], e[4:1]});
    end

    // R7 exhaustive add against arithmetic, carries crossing every slice
    for (int ci = 0; ci < 2; ci++) begin
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 16; b++) begin
          logic [W:0] exp;
          exp = 5'(a + b + ci);
          apply(2'b10, 1'b0, 1'(ci), 4'(a), 4'(b));
          check("R7 add sweep", {cout_q, res_q}, exp);
        end
      end
    end

    // R8 latency: new inputs do not show before the next edge
    apply(2'b01, 1'b0, 1'b0, 4'b0101, 4'b0010);
    @(negedge clk);
    op_sel = 2'b00; a_in = 4'b0000; b_in = 4'b0000;
    #2;
    check("R8 hold before edge", {cout_q, res_q}, {1'b0, 4'b0111});
    @(posedge clk);
    #5;
    check("R8 update after edge", {cout_q, res_q}, {1'b0, 4'b0000});

    // R8 synchronous reset clears nonzero outputs
    apply(2'b10, 1'b0, 1'b1, 4'b1111, 4'b1111);
    check("R3 pre-reset", {cout_q, res_q}, {1'b1, 4'b1111});
    @(negedge clk);
    rst = 1'b1;
    #2;
    check("R8 reset waits for edge", {cout_q, res_q}, {1'b1, 4'b1111});
    @(posedge clk);
    #5;
    check("R8 reset clears", {cout_q, res_q}, '0);
    @(negedge clk);
    rst = 1'b0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule